// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that moves only in clock cycles where the count enable input is high. Software reaches it through an 8-bit register interface with two ports: a data port and a control port. The count clock enable is nominally a 1.19318 MHz rate derived from the system clock.

The reload value is written through the data port as two bytes, low byte first. Completing the high byte arms the counter. The current count can be read through the same data port as two bytes. A latch command freezes a snapshot of the count, so the two bytes read back form one consistent value.

Three counting behaviours are available: a single terminal-count event, a periodic one-clock low pulse, and a square wave. Any control word addressed to this channel that asks for an unsupported setting does not change the channel and raises a sticky error flag.

Top module: `pit_channel`

## Requirements
- R1: After reset, `tmr_out` and `cfg_err` are 0 and two data-port reads return 0x00 and 0x00.
- R2: Data-port writes alternate. The first sets the low byte of the reload value and the second sets the high byte. After arming, and before any enabled count clock, reading the count returns the written 16-bit value.
- R3: A low-byte write stops any counting in progress and forces `tmr_out` to 0 on the next cycle. The count stays frozen under count clocks until the high byte is written.
- R4: The high-byte write loads the assembled 16-bit value as both period and count. Counting starts only if that value is nonzero. With a value of 0 the count stays at 0 and `tmr_out` stays 0.
- R5: A latch command (control word with access field bits [5:4] = 00) captures the count only if no latch is pending, and it resets the read pointer to the low byte. While the latch is pending, reads return the snapshot. The latch is released after its high byte has been read.
- R6: Data-port reads alternate between the low byte and the high byte of the count.
- R7: Mode 0 (mode field bits [3:1] = 000): `tmr_out` is 0 while armed. It goes to 1 on the count clock that brings the count to 0. Counting then stops, with the count at 0 and `tmr_out` held at 1.
- R8: Mode 2 (bits [3:1] = 010): the count steps N, N-1, ..., 1 and then reloads to N. `tmr_out` is 0 exactly while the count is 1 and 1 otherwise.
- R9: Mode 3 (bits [3:1] = 011): the count steps as in mode 2. `tmr_out` is 1 while the count exceeds floor(N/2), so it is high for ceil(N/2) count clocks and low for floor(N/2).
- R10: A control word is addressed to this channel when select field bits [7:6] equal the channel number (0 by default). Select = 3, or a word addressed to this channel with access 01 or 10, BCD bit [0] = 1, or a mode other than 0, 2 or 3, sets `cfg_err` sticky until reset and changes no other state. Words for other channels are ignored and do not set the error.
- R11: An accepted programming word (access 11, valid mode, BCD 0) sets the mode and stops counting. It forces `tmr_out` to 0, returns both byte pointers to the low byte and drops any pending latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the data port |
| port_sel | input | 1 | 0 selects the data port, 1 the control port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the data port, valid in the cycle of `rd_en` |
| cnt_en | input | 1 | Count clock enable, one count step per enabled cycle |
| tmr_out | output | 1 | Counter output pin |
| cfg_err | output | 1 | Sticky flag for a rejected control word |

## Verification
The hardest situation to bring about is a latch snapshot that differs from the live count at the moment it is read. The stimulus keeps the count clock running after the latch command and issues a second latch before reading, then checks that the snapshot survives until its high byte is read and that the following read shows the live count. A second hard case is a rejected control word arriving while the counter is armed. Random trials arm each mode with a random period, run a random number of count clocks, then latch, advance two more clocks, and compare both the snapshot and the live count against values computed from the period and the tick count.

// File: rtl/pit_pkg.sv
// Shared types for the interval counter channel.
// Assumes an 8-bit control word: [7:6] select, [5:4] access, [3:1] mode, [0] BCD.
package pit_pkg;

    typedef enum logic [1:0] {
        PM_TERM   = 2'd0,
        PM_RATE   = 2'd1,
        PM_SQUARE = 2'd2
    } pit_mode_e;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] ACC_LATCH    = 2'b00;
    localparam logic [1:0] ACC_LOHI     = 2'b11;
    localparam logic [1:0] SEL_READBACK = 2'b11;

endpackage

// File: rtl/pit_ctrl_decode.sv
// Control-word decoder. Combinational: it turns one control-port write into
// at most one of latch, program or reject. Words for other channels give none.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic      wr_ctrl,
    input  logic [7:0] wdata,
    output logic      do_latch,
    output logic      do_prog,
    output logic      bad,
    output pit_mode_e prog_mode
);

    ctrl_word_t cw;
    assign cw = wdata;

    // Classify the control word against the supported settings.
    always_comb begin
        do_latch  = 1'b0;
        do_prog   = 1'b0;
        bad       = 1'b0;
        prog_mode = PM_TERM;
        if (wr_ctrl) begin
            if (cw.sel == SEL_READBACK) begin
                bad = 1'b1;
            end else if (cw.sel == CHAN_ID) begin
                if (cw.acc == ACC_LATCH) begin
                    do_latch = 1'b1;
                end else if (cw.acc != ACC_LOHI || cw.bcd) begin
                    bad = 1'b1;
                end else begin
                    case (cw.mode)
                        3'd0:    begin do_prog = 1'b1; prog_mode = PM_TERM;   end
                        3'd2:    begin do_prog = 1'b1; prog_mode = PM_RATE;   end
                        3'd3:    begin do_prog = 1'b1; prog_mode = PM_SQUARE; end
                        default: bad = 1'b1;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pit_byte_if.sv
// Byte sequencing and latch logic. It assembles the reload value from two
// byte writes (low then high) and serves count reads as low then high bytes,
// from a one-shot snapshot while a latch is pending. Assumes CW = 2*BW.
module pit_byte_if #(
    parameter int BW = 8,
    parameter int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic          rd_data,
    input  logic [BW-1:0] wdata,
    input  logic          do_latch,
    input  logic          do_prog,
    input  logic [CW-1:0] cur_cnt,
    output logic          load_lo,
    output logic          load_full,
    output logic [CW-1:0] load_val,
    output logic [BW-1:0] rdata
);

    logic          wr_hi;
    logic          rd_hi;
    logic          latched;
    logic [BW-1:0] lo_hold;
    logic [CW-1:0] snap;
    logic [CW-1:0] src;

    assign load_lo   = wr_data && !wr_hi;
    assign load_full = wr_data && wr_hi;
    assign load_val  = {wdata, lo_hold};

    // Write pointer and low-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi   <= 1'b0;
            lo_hold <= '0;
        end else if (do_prog) begin
            wr_hi <= 1'b0;
        end else if (wr_data) begin
            wr_hi <= !wr_hi;
            if (!wr_hi) lo_hold <= wdata;
        end
    end

    // Read pointer, latch capture and latch release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi   <= 1'b0;
            latched <= 1'b0;
            snap    <= '0;
        end else if (do_prog) begin
            rd_hi   <= 1'b0;
            latched <= 1'b0;
        end else if (do_latch && !latched) begin
            snap    <= cur_cnt;
            latched <= 1'b1;
            rd_hi   <= 1'b0;
        end else if (rd_data) begin
            rd_hi <= !rd_hi;
            if (rd_hi) latched <= 1'b0;
        end
    end

    // Read data mux: snapshot or live count, byte chosen by the pointer.
    always_comb begin
        src   = latched ? snap : cur_cnt;
        rdata = rd_hi ? src[CW-1:BW] : src[BW-1:0];
    end

    // R5: a pending latch keeps its snapshot until its high byte is read.
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latched && !do_prog && !(rd_data && rd_hi) |=> latched && $stable(snap));

    // R6: each plain data read moves the pointer to the other byte.
    p_rd_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !do_prog && !(do_latch && !latched) |=> rd_hi != $past(rd_hi));

endmodule

// File: rtl/pit_count_core.sv
// Down-counter and output pin. It counts one step per enabled count clock
// while armed, with the output shaped by the programmed mode. It is stopped
// by a low-byte write or a programming word, and armed by a nonzero load.
module pit_count_core
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          stop,
    input  logic          prog,
    input  pit_mode_e     prog_mode,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          out_q
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;
    logic [CW-1:0] nxt;
    logic [CW-1:0] half;
    logic          armed;
    pit_mode_e     mode_q;

    assign count = cnt;

    // Next value for the periodic modes and the square-wave threshold.
    always_comb begin
        nxt  = (cnt == ONE) ? period : cnt - ONE;
        half = period >> 1;
    end

    // Mode register, written by an accepted programming word.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= PM_TERM;
        else if (prog) mode_q <= prog_mode;
    end

    // Counter, period, arm state and output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            period <= '0;
            armed  <= 1'b0;
            out_q  <= 1'b0;
        end else if (stop) begin
            armed <= 1'b0;
            out_q <= 1'b0;
        end else if (load) begin
            period <= load_val;
            cnt    <= load_val;
            armed  <= (load_val != '0);
            out_q  <= (load_val != '0) && (mode_q != PM_TERM)
                      && !(mode_q == PM_RATE && load_val == ONE);
        end else if (armed && tick) begin
            case (mode_q)
                PM_TERM: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) begin
                        out_q <= 1'b1;
                        armed <= 1'b0;
                    end
                end
                PM_RATE: begin
                    cnt   <= nxt;
                    out_q <= (nxt != ONE);
                end
                default: begin
                    cnt   <= nxt;
                    out_q <= (nxt > half);
                end
            endcase
        end
    end

    // R3: a stop forces the pin low on the next cycle.
    p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !out_q);

    // R3: an idle counter does not move.
    p_idle_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !load |=> cnt == $past(cnt));

    // R4: loading zero leaves the counter unarmed.
    p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load && !stop && load_val == '0 |=> !armed);

    // R7: in mode 0 a high pin stays high until the next stop or load.
    p_term_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == PM_TERM && out_q && !stop && !load |=> out_q);

    // R8: the mode 2 low pulse lasts one count clock when the period exceeds 1.
    p_rate_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == PM_RATE && armed && !out_q && tick && !stop && !load
        && !prog && period != ONE |=> out_q);

endmodule

// File: rtl/pit_channel.sv
// One channel of a programmable interval timer: 8-bit data and control
// ports, 16-bit down-counter, count enable input and output pin.
// Assumes wr_en and rd_en are not asserted together; a write takes priority.
module pit_channel
    import pit_pkg::*;
#(
    parameter int         BW      = 8,
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          port_sel,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic          cnt_en,
    output logic          tmr_out,
    output logic          cfg_err
);

    localparam int CW = 2 * BW;

    logic          wr_data;
    logic          wr_ctrl;
    logic          rd_data;
    logic          do_latch;
    logic          do_prog;
    logic          bad;
    pit_mode_e     prog_mode;
    logic          load_lo;
    logic          load_full;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cur_cnt;

    assign wr_data = wr_en && !port_sel;
    assign wr_ctrl = wr_en && port_sel;
    assign rd_data = rd_en && !port_sel && !wr_en;

    pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata[7:0]),
        .do_latch  (do_latch),
        .do_prog   (do_prog),
        .bad       (bad),
        .prog_mode (prog_mode)
    );

    pit_byte_if #(.BW(BW), .CW(CW)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wdata     (wdata),
        .do_latch  (do_latch),
        .do_prog   (do_prog),
        .cur_cnt   (cur_cnt),
        .load_lo   (load_lo),
        .load_full (load_full),
        .load_val  (load_val),
        .rdata     (rdata)
    );

    pit_count_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_en),
        .stop      (load_lo || do_prog),
        .prog      (do_prog),
        .prog_mode (prog_mode),
        .load      (load_full),
        .load_val  (load_val),
        .count     (cur_cnt),
        .out_q     (tmr_out)
    );

    // Sticky error flag for rejected control words.
    always_ff @(posedge clk) begin
        if (!rst_n)   cfg_err <= 1'b0;
        else if (bad) cfg_err <= 1'b1;
    end

    // R10: once raised, the error flag stays until reset.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R10: a rejected word is flagged on the next cycle.
    p_err_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> cfg_err);

endmodule

// File: tb/pit_channel_test.sv
`timescale 1ns/1ps
module pit_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cnt_en = 1'b0;
    logic       tmr_out;
    logic       cfg_err;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pit_channel uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_sel (port_sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .cnt_en   (cnt_en),
        .tmr_out  (tmr_out),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_wr(input logic ps, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; port_sel = ps; wdata = b;
        @(negedge clk);
        wr_en = 1'b0; port_sel = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] b);
        @(negedge clk);
        rd_en = 1'b1; port_sel = 1'b0;
        #1 b = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        do_rd(lo);
        do_rd(hi);
        v = {hi, lo};
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic arm(input logic [7:0] cw, input int n);
        do_wr(1'b1, cw);
        do_wr(1'b0, n[7:0]);
        do_wr(1'b0, n[15:8]);
    endtask

    // Mode code 0, 2 or 3; period n; k count clocks since arming.
    function automatic int exp_cnt(input int m, input int n, input int k);
        if (m == 0) return (k >= n) ? 0 : n - k;
        return n - (k % n);
    endfunction

    function automatic int exp_out(input int m, input int n, input int k);
        int c;
        c = exp_cnt(m, n, k);
        if (m == 0) return (k >= n) ? 1 : 0;
        if (m == 2) return (c != 1) ? 1 : 0;
        return (c > n / 2) ? 1 : 0;
    endfunction

    function automatic logic [7:0] mode_cw(input int m);
        return {2'b00, 2'b11, m[2:0], 1'b0};
    endfunction

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        logic [7:0] b;
        logic [7:0] badw [6];
        void'($urandom(32'd20240601));
        badw[0] = 8'hC0; badw[1] = 8'h10; badw[2] = 8'h20;
        badw[3] = 8'h31; badw[4] = 8'h32; badw[5] = 8'h38;

        // R1: reset state
        do_reset();
        chk("R1 out", tmr_out, 0);
        chk("R1 err", cfg_err, 0);
        do_rd(b); chk("R1 read lo", b, 0);
        do_rd(b); chk("R1 read hi", b, 0);

        // R2, R6: byte order on write and read
        arm(8'h30, 16'h1234);
        do_rd(b); chk("R2 R6 low byte", b, 8'h34);
        do_rd(b); chk("R2 R6 high byte", b, 8'h12);
        do_rd(b); chk("R6 back to low byte", b, 8'h34);
        do_rd(b);
        chk("R2 mode0 out while armed", tmr_out, 0);

        // R7: mode 0 terminal count
        arm(8'h30, 3);
        run_ticks(2);
        chk("R7 out before tc", tmr_out, 0);
        rd16(v); chk("R7 count before tc", v, 1);
        run_ticks(1);
        chk("R7 out at tc", tmr_out, 1);
        run_ticks(3);
        chk("R7 out held", tmr_out, 1);
        rd16(v); chk("R7 count stays 0", v, 0);

        // R3: low-byte write stops counting and drops the pin
        arm(8'h34, 16'h0100);
        run_ticks(5);
        do_wr(1'b0, 8'h22);
        chk("R3 out low after lsb", tmr_out, 0);
        run_ticks(4);
        rd16(v); chk("R3 count frozen", v, 16'h00FB);
        do_wr(1'b0, 8'h00);
        rd16(v); chk("R4 reload after msb", v, 16'h0022);
        chk("R4 mode2 out armed", tmr_out, 1);

        // R4: zero period is not armed
        arm(8'h30, 0);
        run_ticks(5);
        rd16(v); chk("R4 zero count idle", v, 0);
        chk("R4 zero out low", tmr_out, 0);

        // R5: latch snapshot, second latch ignored, release after high byte
        arm(8'h34, 100);
        run_ticks(10);
        do_wr(1'b1, 8'h00);
        run_ticks(5);
        do_wr(1'b1, 8'h00);
        run_ticks(3);
        rd16(v); chk("R5 snapshot kept", v, 90);
        rd16(v); chk("R5 live after release", v, 82);

        // R8: mode 2 pulse
        arm(8'h34, 3);
        chk("R8 out after arm", tmr_out, 1);
        run_ticks(1); chk("R8 tick1 out", tmr_out, 1);
        run_ticks(1); chk("R8 tick2 out low", tmr_out, 0);
        rd16(v); chk("R8 count at pulse", v, 1);
        run_ticks(1); chk("R8 tick3 out", tmr_out, 1);
        rd16(v); chk("R8 reload", v, 3);

        // R9: mode 3 with odd period 5: 1,1,1,0,0,1
        arm(8'h36, 5);
        chk("R9 out k0", tmr_out, 1);
        for (int k = 1; k <= 6; k++) begin
            run_ticks(1);
            chk($sformatf("R9 out k%0d", k), tmr_out, exp_out(3, 5, k));
        end

        // R10: each rejected word raises the flag and changes nothing
        for (int i = 0; i < 6; i++) begin
            do_reset();
            arm(8'h30, 10);
            run_ticks(2);
            do_wr(1'b1, badw[i]);
            chk($sformatf("R10 err word %0h", badw[i]), cfg_err, 1);
            run_ticks(3);
            rd16(v); chk($sformatf("R10 still counting %0h", badw[i]), v, 5);
        end
        do_reset();
        arm(8'h30, 10);
        run_ticks(2);
        do_wr(1'b1, 8'h70);
        chk("R10 other channel no err", cfg_err, 0);
        run_ticks(3);
        rd16(v); chk("R10 other channel ignored", v, 5);

        // R11: programming word stops counting and resets pointers
        arm(8'h34, 20);
        run_ticks(3);
        chk("R11 out before prog", tmr_out, 1);
        do_wr(1'b1, 8'h30);
        chk("R11 out low after prog", tmr_out, 0);
        run_ticks(4);
        rd16(v); chk("R11 count frozen", v, 17);
        do_wr(1'b0, 8'h55);
        arm(8'h34, 5);
        rd16(v); chk("R11 write pointer reset", v, 5);
        do_wr(1'b1, 8'h00);
        do_wr(1'b1, 8'h34);
        do_rd(b); chk("R11 latch dropped", b, 8'h05);
        do_rd(b);

        // Random trials across modes, periods and tick counts
        for (int t = 0; t < 24; t++) begin
            int m, n, k;
            m = $urandom_range(0, 2);
            if (m > 0) m = m + 1;
            n = $urandom_range(1, 60);
            k = $urandom_range(0, 3 * n);
            arm(mode_cw(m), n);
            run_ticks(k);
            chk($sformatf("R7 R8 R9 out m%0d n%0d k%0d", m, n, k), tmr_out, exp_out(m, n, k));
            do_wr(1'b1, 8'h00);
            run_ticks(2);
            rd16(v); chk($sformatf("R5 snapshot m%0d n%0d k%0d", m, n, k), v, exp_cnt(m, n, k));
            rd16(v); chk($sformatf("R2 live m%0d n%0d k%0d", m, n, k), v, exp_cnt(m, n, k + 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule